// File: doc/BRIEF.md
# Debug Halt and Resume Controller

This block sits next to a small processor core and decides when that core is held still for debugging and when it may run again. A host debugger reaches it through a simple register access port: an address, write data, a write strobe and a read strobe. This port stands in for a scan-chain path. The top bit of the address splits the space into two halves. The lower half holds the controller's own registers. The upper half is passed straight through to the system memory bus, so the host can load and inspect memory without involving the core.

The controller has three registers. The stop-enable register has one bit per exception type. The reason register records why the core stopped. The mode register carries a single-step bit. The stall output is high exactly while the reason register holds any set bit. There is no separate halt flag. The host finds out that the core has stopped by polling the reason register, and it lets the core go again by writing zero to that register. Exception events come from another clock domain, so each one is synchronised and edge-detected before it can record a reason. With single-step enabled, every retired instruction records a trap reason, which stops the core again after one instruction. This is how the host regains control of a core that is spinning in an endless loop.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the stop-enable, reason and mode registers all read as zero and `dbg_stall` is low.
- R2: A rising edge on `exc_async[i]` whose stop-enable bit i is set sets reason bit i. The reason register is visible from the third rising clock edge after the input rises, and `dbg_stall` goes high in the same cycle.
- R3: A rising edge on `exc_async[i]` whose stop-enable bit i is clear leaves the reason register unchanged and does not raise `dbg_stall`.
- R4: `dbg_stall` is high exactly while the reason register is nonzero. A host write of zero to the reason register drops the stall on the clock edge that performs the write.
- R5: An exception input that stays high is recorded once, on its rising edge. After the host clears the reason register, the held level does not set the reason again.
- R6: When mode bit 0 (single-step) is set, an `instr_retired` pulse sets reason bit NEXC (bit 4 by default), the step-trap bit, on the same clock edge. When mode bit 0 is clear, a retire pulse has no effect.
- R7: A host write to the reason register wins over a hardware set in the same cycle. The register takes the written value, and the colliding event is recorded on the following clock edge.
- R8: A read returns data in `host_rdata` one cycle after the strobe. In the register half the map is: offset 0 = stop-enable (bits NEXC-1:0), offset 1 = reason (bits NEXC:0), offset 2 = mode (bit 0 = single-step). Any other register-half offset reads as zero.
- R9: An access with address bit AW-1 set drives `mem_req` in the same cycle, with `mem_we`, the lower AW-1 address bits on `mem_addr` and `host_wdata` on `mem_wdata`. Such an access does not change the controller registers. A read in that half returns `mem_rdata` one cycle later.
- R10: Accesses to the register half never assert `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | AW | Host access address; top bit selects memory half |
| host_wdata | input | DW | Host write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | DW | Read data, one cycle after the strobe |
| mem_req | output | 1 | System bus request for memory-half accesses |
| mem_we | output | 1 | System bus write enable |
| mem_addr | output | AW-1 | System bus address |
| mem_wdata | output | DW | System bus write data |
| mem_rdata | input | DW | System bus read data, valid the cycle after the request |
| exc_async | input | NEXC | Exception event levels from another clock domain |
| instr_retired | input | 1 | One-cycle pulse per retired instruction |
| dbg_stall | output | 1 | Holds the core while any reason bit is set |

## Verification
A vector table drives the exception inputs and the stop-enable register with several pairs of patterns: single bits, all bits, fully masked, and partly overlapping. These pairs show whether masking works per bit and whether each event lands in its own reason bit rather than in a neighbouring one. Directed sequences then cover the rest. They measure the three-edge synchronisation latency against early and late sampling. They hold an input high after clearing, to tell an edge from a level. They time a host clear into the same cycle as an event, to separate write priority from a lost event. They toggle single-step to show that only the retire pulse, and only while stepping, sets the trap bit. Accesses to both halves of the address space show that reads are routed to the right source and that memory writes do not leak into the registers.

// File: rtl/dbghc_pkg.sv
// Package: shared constants and types for the debug halt controller.
// Assumes the register half of the host port uses small offsets only.
package dbghc_pkg;
    parameter int unsigned OFS_STOPEN = 0;
    parameter int unsigned OFS_REASON = 1;
    parameter int unsigned OFS_MODE   = 2;
    parameter int unsigned MODE_STEP  = 0;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STOPEN = 2'd1,
        SEL_REASON = 2'd2,
        SEL_MODE   = 2'd3
    } dbghc_sel_e;

    typedef struct packed {
        logic stopen;
        logic reason;
        logic mode;
    } dbghc_wr_t;
endpackage

// File: rtl/dbghc_evsync.sv
// Module: brings exception levels from a foreign clock domain into the
// core domain. Each bit has a two-flop synchroniser and a rising-edge
// detector, and produces a one-cycle pulse per rising edge.
// Assumes each input level stays stable for at least two core clocks.
module dbghc_evsync #(
    parameter int NEXC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXC-1:0] lvl_async,
    output logic [NEXC-1:0] evt_pulse
);
    logic [NEXC-1:0] meta_q;
    logic [NEXC-1:0] sync_q;
    logic [NEXC-1:0] prev_q;

    for (genvar i = 0; i < NEXC; i++) begin : g_bit
        // Purpose: three-stage shift (two sync stages plus a history stage).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= lvl_async[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end

        // Purpose: single-cycle pulse on a synchronised rising edge.
        always_comb evt_pulse[i] = sync_q[i] & ~prev_q[i];
    end

    // R5: an edge pulse never lasts two cycles, so a held level fires once.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_pulse & $past(evt_pulse)) == '0));
endmodule

// File: rtl/dbghc_hostport.sv
// Module: host access port. Splits the address space on its top bit:
// the lower half decodes into controller register strobes, the upper
// half is forwarded to the system memory bus. Read data is registered,
// so it appears one cycle after the read strobe.
// Assumes the memory bus returns read data in the cycle after a request.
module dbghc_hostport
    import dbghc_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int NEXC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    input  logic            host_we,
    input  logic            host_re,
    output logic [DW-1:0]   host_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-2:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [NEXC-1:0] stopen_val,
    input  logic [NEXC:0]   reason_val,
    input  logic            step_val,
    output dbghc_wr_t       wr
);
    localparam int OW = AW - 1;

    logic       is_mem;
    logic [OW-1:0] ofs;
    dbghc_sel_e sel;
    logic [DW-1:0] reg_rd;
    logic [DW-1:0] rdata_q;
    logic          mem_sel_q;

    // Purpose: split the address into half-select and offset.
    always_comb begin
        is_mem = host_addr[AW-1];
        ofs    = host_addr[OW-1:0];
    end

    // Purpose: decode the register-half offset into a register select.
    always_comb begin
        sel = SEL_NONE;
        if (!is_mem) begin
            if (ofs == OW'(OFS_STOPEN))      sel = SEL_STOPEN;
            else if (ofs == OW'(OFS_REASON)) sel = SEL_REASON;
            else if (ofs == OW'(OFS_MODE))   sel = SEL_MODE;
        end
    end

    // Purpose: write strobes toward the register bank.
    always_comb begin
        wr.stopen = host_we && (sel == SEL_STOPEN);
        wr.reason = host_we && (sel == SEL_REASON);
        wr.mode   = host_we && (sel == SEL_MODE);
    end

    // Purpose: forward memory-half accesses to the system bus.
    always_comb begin
        mem_req   = is_mem && (host_we || host_re);
        mem_we    = is_mem && host_we;
        mem_addr  = ofs;
        mem_wdata = host_wdata;
    end

    // Purpose: select the register value for a read of the register half.
    always_comb begin
        case (sel)
            SEL_STOPEN: reg_rd = DW'(stopen_val);
            SEL_REASON: reg_rd = DW'(reason_val);
            SEL_MODE:   reg_rd = DW'(step_val);
            default:    reg_rd = '0;
        endcase
    end

    // Purpose: capture read data and remember which half was read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            mem_sel_q <= 1'b0;
        end else if (host_re) begin
            rdata_q   <= reg_rd;
            mem_sel_q <= is_mem;
        end
    end

    // Purpose: return memory data or the captured register data.
    always_comb host_rdata = mem_sel_q ? mem_rdata : rdata_q;

    // R10: a register-half access never reaches the memory bus.
    a_r10_no_mem_for_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_addr[AW-1]) |-> !mem_req);
    // R9: a memory-half access never produces a register write strobe.
    a_r9_mem_no_regwrite: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr[AW-1] |-> !(wr.stopen || wr.reason || wr.mode));
endmodule

// File: rtl/dbghc_regs.sv
// Module: register bank holding stop-enable, reason and mode. Merges
// hardware reason sets (enabled exception pulses, single-step trap)
// with host writes. A host write to reason wins, and a colliding set
// is held over and applied on the next edge. Stall is the OR of reason.
// Assumes exception pulses are already synchronous to clk.
module dbghc_regs
    import dbghc_pkg::*;
#(
    parameter int NEXC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dbghc_wr_t       wr,
    input  logic [NEXC:0]   wr_data,
    input  logic [NEXC-1:0] evt_pulse,
    input  logic            instr_retired,
    output logic [NEXC-1:0] stopen_q,
    output logic [NEXC:0]   reason_q,
    output logic            step_q,
    output logic            stall
);
    localparam int RW   = NEXC + 1;
    localparam int TRAP = NEXC;

    logic [RW-1:0] hw_set;
    logic [RW-1:0] pend_q;

    // Purpose: collect hardware reason sets for this cycle.
    always_comb begin
        hw_set             = '0;
        hw_set[NEXC-1:0]   = evt_pulse & stopen_q;
        hw_set[TRAP]       = step_q & instr_retired;
    end

    // Purpose: stop-enable and mode registers, written by the host only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopen_q <= '0;
            step_q   <= 1'b0;
        end else begin
            if (wr.stopen) stopen_q <= wr_data[NEXC-1:0];
            if (wr.mode)   step_q   <= wr_data[MODE_STEP];
        end
    end

    // Purpose: reason register with host priority and deferred capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reason_q <= '0;
            pend_q   <= '0;
        end else if (wr.reason) begin
            reason_q <= wr_data;
            pend_q   <= pend_q | hw_set;
        end else begin
            reason_q <= reason_q | hw_set | pend_q;
            pend_q   <= '0;
        end
    end

    // Purpose: the core is held exactly while any reason bit is set.
    always_comb stall = |reason_q;

    // R7: a host write to reason lands exactly as written.
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr.reason |=> (reason_q == $past(wr_data)));
    // R2: an enabled exception pulse sets its reason bit on the next edge.
    a_r2_enabled_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.reason && ((evt_pulse & stopen_q) != '0))
        |=> ((reason_q[NEXC-1:0] & $past(evt_pulse & stopen_q)) == $past(evt_pulse & stopen_q)));
    // R3: with no enabled event, trap, pending set or write, reason holds.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.reason && ((evt_pulse & stopen_q) == '0) && (pend_q == '0)
         && !(step_q && instr_retired)) |=> $stable(reason_q));
    // R6: a retire while stepping sets the trap bit.
    a_r6_step_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.reason && step_q && instr_retired) |=> reason_q[TRAP]);
endmodule

// File: rtl/dbg_halt_ctrl.sv
// Module: top of the debug halt and resume controller. Connects the
// event synchroniser, the host port and the register bank, and drives
// the stall output to the core.
// Assumes NEXC + 1 <= DW so the reason register fits a data word.
module dbg_halt_ctrl #(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int NEXC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    input  logic            host_we,
    input  logic            host_re,
    output logic [DW-1:0]   host_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-2:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [NEXC-1:0] exc_async,
    input  logic            instr_retired,
    output logic            dbg_stall
);
    localparam int RW = NEXC + 1;

    dbghc_pkg::dbghc_wr_t wr;
    logic [NEXC-1:0] evt_pulse;
    logic [NEXC-1:0] stopen_q;
    logic [RW-1:0]   reason_q;
    logic            step_q;

    dbghc_evsync #(.NEXC(NEXC)) u_evsync (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_async (exc_async),
        .evt_pulse (evt_pulse)
    );

    dbghc_hostport #(.AW(AW), .DW(DW), .NEXC(NEXC)) u_hostport (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_rdata (host_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .stopen_val (stopen_q),
        .reason_val (reason_q),
        .step_val   (step_q),
        .wr         (wr)
    );

    dbghc_regs #(.NEXC(NEXC)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (wr),
        .wr_data       (host_wdata[RW-1:0]),
        .evt_pulse     (evt_pulse),
        .instr_retired (instr_retired),
        .stopen_q      (stopen_q),
        .reason_q      (reason_q),
        .step_q        (step_q),
        .stall         (dbg_stall)
    );

    // R4: stall falls on the edge that writes zero to the reason register.
    a_r4_clear_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.reason && host_wdata[RW-1:0] == '0 && evt_pulse == '0) |=> !dbg_stall);
endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NEXC = 4;
    localparam logic [AW-1:0] A_EN = 8'h00, A_RS = 8'h01, A_MD = 8'h02;

    logic clk = 0;
    logic rst_n = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic host_we = 0, host_re = 0;
    logic [DW-1:0] host_rdata;
    logic mem_req, mem_we;
    logic [AW-2:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = 16'hBEEF;
    logic [NEXC-1:0] exc_async = '0;
    logic instr_retired = 0;
    logic dbg_stall;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] rd;

    always #2 clk = ~clk;

    dbg_halt_ctrl #(.AW(AW), .DW(DW), .NEXC(NEXC)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .exc_async(exc_async), .instr_retired(instr_retired),
        .dbg_stall(dbg_stall)
    );

    typedef struct packed {
        logic [NEXC-1:0] en;
        logic [NEXC-1:0] exc;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{en: 4'b0001, exc: 4'b0001},
        '{en: 4'b1111, exc: 4'b1000},
        '{en: 4'b0000, exc: 4'b1111},
        '{en: 4'b1010, exc: 4'b0110},
        '{en: 4'b1111, exc: 4'b1111},
        '{en: 4'b0101, exc: 4'b1010}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        host_addr = a; host_wdata = d; host_we = 1;
        @(posedge clk); @(negedge clk);
        host_we = 0;
    endtask

    task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        host_addr = a; host_re = 1;
        @(posedge clk); @(negedge clk);
        host_re = 0;
        d = host_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1: reset state
        check("R1 stall", DW'(dbg_stall), 0);
        host_read(A_EN, rd); check("R1 stopen", rd, 0);
        host_read(A_RS, rd); check("R1 reason", rd, 0);
        host_read(A_MD, rd); check("R1 mode", rd, 0);

        // R2/R3: vector table of enable/event patterns
        for (int v = 0; v < NV; v++) begin
            logic [NEXC-1:0] exp;
            exp = VECS[v].en & VECS[v].exc;
            host_write(A_EN, DW'(VECS[v].en));
            host_write(A_RS, 0);
            exc_async = VECS[v].exc;
            idle(4);
            exc_async = '0;
            idle(3);
            check(exp != 0 ? "R2 stall" : "R3 no stall", DW'(dbg_stall), DW'(exp != 0));
            host_read(A_RS, rd);
            check(exp != 0 ? "R2 reason" : "R3 reason", rd, DW'(exp));
            host_write(A_RS, 0);
            check("R4 cleared resumes", DW'(dbg_stall), 0);
        end

        // R2: latency of three edges
        host_write(A_EN, 16'h000F);
        exc_async = 4'b0100;
        idle(1); check("R2 not after e1", DW'(dbg_stall), 0);
        idle(1); check("R2 not after e2", DW'(dbg_stall), 0);
        idle(1); check("R2 stall after e3", DW'(dbg_stall), 1);
        // R5: clear while the level is still held; no re-set
        host_write(A_RS, 0);
        idle(5);
        check("R5 held level once", DW'(dbg_stall), 0);
        exc_async = '0;
        idle(4);

        // R3: disabled bit on top of an existing reason leaves it unchanged
        host_write(A_EN, 16'h0001);
        exc_async = 4'b0001; idle(4); exc_async = '0; idle(3);
        exc_async = 4'b0010; idle(4); exc_async = '0; idle(3);
        host_read(A_RS, rd); check("R3 reason unchanged", rd, 16'h0001);
        host_write(A_RS, 0);

        // R7: host clear collides with an event pulse
        host_write(A_EN, 16'h0002);
        exc_async = 4'b0010;
        idle(2);
        host_write(A_RS, 0);
        check("R7 write wins", DW'(dbg_stall), 0);
        idle(1);
        check("R7 deferred capture", DW'(dbg_stall), 1);
        host_read(A_RS, rd); check("R7 reason bit", rd, 16'h0002);
        exc_async = '0;
        idle(3);
        host_write(A_RS, 0);

        // R6: single-step trap on retire
        instr_retired = 1; idle(1); instr_retired = 0;
        check("R6 no trap when off", DW'(dbg_stall), 0);
        host_write(A_MD, 16'h0001);
        host_read(A_MD, rd); check("R8 mode readback", rd, 16'h0001);
        instr_retired = 1; idle(1); instr_retired = 0;
        check("R6 trap stall", DW'(dbg_stall), 1);
        host_read(A_RS, rd); check("R6 trap bit", rd, 16'h0010);
        host_write(A_RS, 0);
        check("R4 resume after trap", DW'(dbg_stall), 0);
        idle(2);
        check("R6 no retire no trap", DW'(dbg_stall), 0);
        host_write(A_MD, 0);

        // R8: readback and unmapped offset
        host_write(A_EN, 16'h000B);
        host_read(A_EN, rd); check("R8 stopen readback", rd, 16'h000B);
        host_read(8'h05, rd); check("R8 unmapped zero", rd, 0);
        host_read(8'h7F, rd); check("R8 unmapped top", rd, 0);

        // R9/R10: memory half routing
        host_addr = 8'h83; host_wdata = 16'h5A5A; host_we = 1;
        #1;
        check("R9 mem_req", DW'(mem_req), 1);
        check("R9 mem_we", DW'(mem_we), 1);
        check("R9 mem_addr", DW'(mem_addr), 16'h0003);
        check("R9 mem_wdata", mem_wdata, 16'h5A5A);
        @(posedge clk); @(negedge clk); host_we = 0;
        host_addr = 8'h00; host_we = 1; host_wdata = 16'h000B;
        #1; check("R10 no mem_req", DW'(mem_req), 0);
        @(posedge clk); @(negedge clk); host_we = 0;
        host_read(A_EN, rd); check("R9 regs untouched", rd, 16'h000B);
        host_read(A_RS, rd); check("R9 reason untouched", rd, 0);
        host_read(8'h81, rd); check("R9 mem read data", rd, 16'hBEEF);

        // R1: reset clears everything again
        host_write(A_MD, 1);
        instr_retired = 1; idle(1); instr_retired = 0;
        rst_n = 0; idle(2); rst_n = 1; idle(1);
        check("R1 stall after reset", DW'(dbg_stall), 0);
        host_read(A_EN, rd); check("R1 stopen after reset", rd, 0);
        host_read(A_MD, rd); check("R1 mode after reset", rd, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule